// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves incoming frames into a ring of receive descriptors that lives in memory shared with a host. A frame arrives as a byte stream with its length presented alongside. The block looks for a descriptor the host has handed to the device, reads that descriptor's buffer pointer, and records the received length. It then copies the frame bytes into the buffer and, as its final memory write, returns the descriptor to the host. A one-cycle event pulse then tells the register block to raise its receive and summary interrupt flags.

The ring holds 2^RING_LOG descriptors of 8 bytes each, starting at `ring_base`. Within a descriptor, offset 0 holds the low 16 bits of the buffer address, offset 2 the flag byte, offset 3 the high 8 bits of the buffer address, offset 4 the buffer length (a negative two's-complement value that this block does not use), and offset 6 the received count. The flag byte uses bit 7 for device ownership and bits 6..2 for error summary, framing, overflow, CRC and buffer errors, which this block never sets. Bit 1 marks start of packet and bit 0 end of packet.

Every 16-bit field is stored most significant byte first, at the lower address. The memory port puts `mem_wdata[7:0]` at `mem_addr` and `mem_wdata[15:8]` at `mem_addr+1`, and reads back in the same lane order, so the block swaps bytes on every 16-bit access. Read data is valid in the cycle after the read request.

Top module: `rxr_ring_writer`

## Requirements
- R1: A descriptor is taken only when its flag byte equals exactly 0x80. Any other value, including 0x80 with an extra bit set, is passed over and left unchanged.
- R2: The search begins at the saved receive index and wraps modulo the ring size. It examines at most ring size minus one entries, so the entry just before the saved index is never examined. When no entry qualifies, the frame is dropped and no descriptor changes.
- R3: For an accepted frame, the received-count field at offset 6 is written with the frame length plus 4, high byte at the lower address.
- R4: The frame bytes are written in order, one byte per accepted beat, starting at the buffer address. The buffer address is formed from the offset-3 byte as bits 23..16 and the big-endian offset-0 field as bits 15..0.
- R5: The last memory write of an accepted frame is the byte 0x03 to the flag byte (start and end of packet, host-owned). `rx_event` pulses for exactly one cycle, in that same cycle, once per accepted frame, and never for a dropped frame.
- R6: After an accepted frame, the saved receive index advances by exactly one modulo the ring size, whichever entry was taken. A dropped frame leaves the index unchanged.
- R7: A frame whose first beat is offered while `rx_stop` is high is consumed without any memory write and without an event.
- R8: `fr_ready` stays low while descriptors are being read or written. A dropped frame is still consumed beat by beat, and reads and writes are never requested in the same cycle.
- R9: After reset, `fr_ready`, `rx_event` and both memory requests are low, and the saved receive index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_base | input | AW | Byte address of descriptor 0, 8-byte aligned |
| rx_stop | input | 1 | When high at frame start, the frame is discarded |
| fr_valid | input | 1 | Frame beat valid; must stay high until the whole frame is taken |
| fr_ready | output | 1 | Block accepts a frame beat this cycle |
| fr_data | input | 8 | Frame byte |
| fr_len | input | LW | Frame length in bytes (at least 1), stable for the whole frame |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_half | output | 1 | 1: 16-bit access, 0: byte access |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 16 | Write data, low lane at `mem_addr` |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_re` |
| rx_event | output | 1 | One-cycle pulse when a frame has been handed to the host |

## Verification
The descriptor updates for a frame are complete one cycle after the beat that carries its last byte. The count write comes before the first data beat, and the flag write and `rx_event` fall in the cycle after the last beat. The bench therefore waits four cycles after its last accepted beat before it reads back the modelled memory, and it counts events and memory writes with monitors across the whole frame instead of sampling single cycles. A beat counts as accepted only when the bench saw `fr_ready` high at the falling edge before the rising edge that takes it. Scan length and buffer pointer reads vary, so no check depends on a fixed latency from the first beat.

// File: rtl/rxr_pkg.sv
// Shared constants, types and helpers for the receive descriptor ring writer.
// Assumes descriptors of 8 bytes with big-endian 16-bit fields.
package rxr_pkg;

    localparam int unsigned DESC_SHIFT = 3;         // 8-byte descriptor stride
    localparam logic [2:0]  OFS_BUF_LO = 3'd0;      // buffer address bits 15..0
    localparam logic [2:0]  OFS_FLAG   = 3'd2;      // ownership / status byte
    localparam logic [2:0]  OFS_BUF_HI = 3'd3;      // buffer address bits 23..16
    localparam logic [2:0]  OFS_COUNT  = 3'd6;      // received byte count
    localparam logic [7:0]  FLAG_DEV_OWNED = 8'h80; // handed to the device
    localparam logic [7:0]  FLAG_RETURNED  = 8'h03; // host-owned, start + end
    localparam logic [15:0] CHECK_BYTES    = 16'd4; // frame check added to count

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FLAG_RD,
        ST_FLAG_CHK,
        ST_LO_RD,
        ST_HI_RD,
        ST_CNT_WR,
        ST_DATA,
        ST_FLAG_WR,
        ST_DRAIN
    } rxr_state_e;

    // One memory request as issued by the controller, before formatting.
    typedef struct packed {
        logic        rd;
        logic        wr;
        logic        half;
        logic        to_buf;   // 1: use buffer pointer, 0: descriptor field
        logic [2:0]  ofs;      // descriptor field offset
        logic [15:0] data;     // native-order value to write
    } mem_req_t;

    function automatic logic [15:0] swap16(input logic [15:0] v);
        return {v[7:0], v[15:8]};
    endfunction

endpackage

// File: rtl/rxr_ring_ptr.sv
// Ring index keeper: holds the saved receive index, the scan cursor and the
// number of entries examined so far. Assumes RING_LOG >= 1.
module rxr_ring_ptr #(
    parameter int RING_LOG = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scan_start,
    input  logic                scan_step,
    input  logic                idx_commit,
    output logic [RING_LOG-1:0] cur,
    output logic                last_try
);
    localparam int unsigned RING = 1 << RING_LOG;
    localparam logic [RING_LOG-1:0] LAST_CNT = RING_LOG'(RING - 2);

    logic [RING_LOG-1:0] idx_q;
    logic [RING_LOG-1:0] cnt_q;

    // Cursor and scan counter: load from saved index, then step with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur   <= '0;
            cnt_q <= '0;
        end else if (scan_start) begin
            cur   <= idx_q;
            cnt_q <= '0;
        end else if (scan_step) begin
            cur   <= cur + 1'b1;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Saved index: one step forward per accepted frame.
    always_ff @(posedge clk) begin
        if (!rst_n)          idx_q <= '0;
        else if (idx_commit) idx_q <= idx_q + 1'b1;
    end

    assign last_try = (cnt_q == LAST_CNT);

endmodule

// File: rtl/rxr_mem_port.sv
// Memory request formatter: turns controller requests into address, lane
// data and strobes, swapping 16-bit fields to big-endian memory order, and
// returns read data in native order. Read data arrives one cycle after mem_re.
module rxr_mem_port
    import rxr_pkg::*;
#(
    parameter int AW           = 24,
    parameter int RING_LOG     = 3,
    parameter bit BASE_ALIGNED = 1'b0   // 1: ring_base aligned to the ring span
) (
    input  logic                clk,
    input  logic                rst_n,
    input  mem_req_t            req,
    input  logic [RING_LOG-1:0] cur,
    input  logic [AW-1:0]       ring_base,
    input  logic [AW-1:0]       buf_ptr,
    input  logic [15:0]         mem_rdata,
    output logic                mem_re,
    output logic                mem_we,
    output logic                mem_half,
    output logic [AW-1:0]       mem_addr,
    output logic [15:0]         mem_wdata,
    output logic [15:0]         rd_val
);
    logic [AW-1:0] desc_addr;
    logic          half_q;

    // Descriptor field address: adder or plain concatenation by parameter.
    generate
        if (BASE_ALIGNED) begin : g_concat
            assign desc_addr = {ring_base[AW-1:RING_LOG+DESC_SHIFT], cur, req.ofs};
        end else begin : g_adder
            assign desc_addr = ring_base
                             + AW'({cur, {DESC_SHIFT{1'b0}}})
                             + AW'(req.ofs);
        end
    endgenerate

    // Request strobes and write lanes.
    always_comb begin
        mem_re    = req.rd;
        mem_we    = req.wr;
        mem_half  = req.half;
        mem_addr  = req.to_buf ? buf_ptr : desc_addr;
        mem_wdata = req.half ? swap16(req.data) : {8'h00, req.data[7:0]};
    end

    // Remember the width of the last read for the return path.
    always_ff @(posedge clk) begin
        if (!rst_n)      half_q <= 1'b0;
        else if (req.rd) half_q <= req.half;
    end

    assign rd_val = half_q ? swap16(mem_rdata) : {8'h00, mem_rdata[7:0]};

endmodule

// File: rtl/rxr_ctrl.sv
// Frame sequencer: scans for a device-owned descriptor, fetches its buffer
// pointer, writes the count, streams the frame bytes and returns the entry.
// Assumes fr_len >= 1 and that fr_len stays stable for the whole frame.
module rxr_ctrl
    import rxr_pkg::*;
#(
    parameter int AW = 24,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_stop,
    input  logic          fr_valid,
    input  logic [7:0]    fr_data,
    input  logic [LW-1:0] fr_len,
    input  logic [15:0]   rd_val,
    input  logic          last_try,
    output logic          fr_ready,
    output logic          rx_event,
    output logic          scan_start,
    output logic          scan_step,
    output logic          idx_commit,
    output mem_req_t      req,
    output logic [AW-1:0] buf_ptr
);
    rxr_state_e    state_q, state_d;
    logic [LW-1:0] len_q;
    logic [LW-1:0] beat_q;
    logic [15:0]   lo_q;
    logic          take;
    logic          beat_last;

    assign take      = fr_valid && fr_ready;
    assign beat_last = (beat_q == len_q - 1'b1);

    // Next state, memory requests and handshake per state.
    always_comb begin
        state_d    = state_q;
        req        = '0;
        fr_ready   = 1'b0;
        rx_event   = 1'b0;
        scan_start = 1'b0;
        scan_step  = 1'b0;
        idx_commit = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (fr_valid) begin
                    if (rx_stop) begin
                        state_d = ST_DRAIN;
                    end else begin
                        scan_start = 1'b1;
                        state_d    = ST_FLAG_RD;
                    end
                end
            end
            ST_FLAG_RD: begin
                req.rd  = 1'b1;
                req.ofs = OFS_FLAG;
                state_d = ST_FLAG_CHK;
            end
            ST_FLAG_CHK: begin
                if (rd_val[7:0] == FLAG_DEV_OWNED) begin
                    state_d = ST_LO_RD;
                end else if (last_try) begin
                    state_d = ST_DRAIN;
                end else begin
                    scan_step = 1'b1;
                    state_d   = ST_FLAG_RD;
                end
            end
            ST_LO_RD: begin
                req.rd   = 1'b1;
                req.half = 1'b1;
                req.ofs  = OFS_BUF_LO;
                state_d  = ST_HI_RD;
            end
            ST_HI_RD: begin
                req.rd  = 1'b1;
                req.ofs = OFS_BUF_HI;
                state_d = ST_CNT_WR;
            end
            ST_CNT_WR: begin
                req.wr   = 1'b1;
                req.half = 1'b1;
                req.ofs  = OFS_COUNT;
                req.data = 16'(len_q) + CHECK_BYTES;
                state_d  = ST_DATA;
            end
            ST_DATA: begin
                fr_ready = 1'b1;
                if (fr_valid) begin
                    req.wr        = 1'b1;
                    req.to_buf    = 1'b1;
                    req.data[7:0] = fr_data;
                    if (beat_last) state_d = ST_FLAG_WR;
                end
            end
            ST_FLAG_WR: begin
                req.wr        = 1'b1;
                req.ofs       = OFS_FLAG;
                req.data[7:0] = FLAG_RETURNED;
                rx_event      = 1'b1;
                idx_commit    = 1'b1;
                state_d       = ST_IDLE;
            end
            ST_DRAIN: begin
                fr_ready = 1'b1;
                if (fr_valid && beat_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Frame length latch and beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= '0;
            beat_q <= '0;
        end else if (state_q == ST_IDLE && fr_valid) begin
            len_q  <= fr_len;
            beat_q <= '0;
        end else if (take) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    // Buffer pointer: assembled from the two address fields, then advanced.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q    <= '0;
            buf_ptr <= '0;
        end else if (state_q == ST_HI_RD) begin
            lo_q <= rd_val;
        end else if (state_q == ST_CNT_WR) begin
            buf_ptr <= AW'({rd_val[7:0], lo_q});
        end else if (state_q == ST_DATA && take) begin
            buf_ptr <= buf_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/rxr_ring_writer.sv
// Top of the receive descriptor ring writer: joins the sequencer, the ring
// index keeper and the memory request formatter.
// Assumes ring_base is 8-byte aligned and a memory with one-cycle read latency.
module rxr_ring_writer
    import rxr_pkg::*;
#(
    parameter int AW           = 24,
    parameter int LW           = 16,
    parameter int RING_LOG     = 3,
    parameter bit BASE_ALIGNED = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ring_base,
    input  logic          rx_stop,
    input  logic          fr_valid,
    output logic          fr_ready,
    input  logic [7:0]    fr_data,
    input  logic [LW-1:0] fr_len,
    output logic          mem_re,
    output logic          mem_we,
    output logic          mem_half,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata,
    output logic          rx_event
);
    mem_req_t            req;
    logic [RING_LOG-1:0] cur;
    logic                last_try;
    logic                scan_start;
    logic                scan_step;
    logic                idx_commit;
    logic [AW-1:0]       buf_ptr;
    logic [15:0]         rd_val;

    rxr_ctrl #(.AW(AW), .LW(LW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_stop    (rx_stop),
        .fr_valid   (fr_valid),
        .fr_data    (fr_data),
        .fr_len     (fr_len),
        .rd_val     (rd_val),
        .last_try   (last_try),
        .fr_ready   (fr_ready),
        .rx_event   (rx_event),
        .scan_start (scan_start),
        .scan_step  (scan_step),
        .idx_commit (idx_commit),
        .req        (req),
        .buf_ptr    (buf_ptr)
    );

    rxr_ring_ptr #(.RING_LOG(RING_LOG)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_start (scan_start),
        .scan_step  (scan_step),
        .idx_commit (idx_commit),
        .cur        (cur),
        .last_try   (last_try)
    );

    rxr_mem_port #(.AW(AW), .RING_LOG(RING_LOG), .BASE_ALIGNED(BASE_ALIGNED)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .cur       (cur),
        .ring_base (ring_base),
        .buf_ptr   (buf_ptr),
        .mem_rdata (mem_rdata),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .mem_half  (mem_half),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .rd_val    (rd_val)
    );

endmodule

// File: rtl/rxr_ring_writer_chk.sv
// Protocol checker for the ring writer, bound to every instance of the top.
module rxr_ring_writer_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fr_ready,
    input logic          mem_re,
    input logic          mem_we,
    input logic          mem_half,
    input logic [AW-1:0] mem_addr,
    input logic [15:0]   mem_wdata,
    input logic          rx_event
);
    // R5
    evt_flag_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |-> (mem_we && !mem_half && mem_wdata[7:0] == 8'h03 && mem_addr[2:0] == 3'd2));

    // R5
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |=> !rx_event);

    // R8
    scan_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> !fr_ready);

    // R8
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    // R6
    evt_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |=> (!fr_ready && !mem_we && !mem_re));

endmodule

bind rxr_ring_writer rxr_ring_writer_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fr_ready  (fr_ready),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .mem_half  (mem_half),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .rx_event  (rx_event)
);

// File: tb/tb_rxr_ring_writer.sv
`timescale 1ns/1ps
module tb_rxr_ring_writer;
    localparam int AW       = 24;
    localparam int LW       = 16;
    localparam int RING_LOG = 3;
    localparam int RING     = 1 << RING_LOG;
    localparam int BASE     = 32'h0000_1000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] ring_base;
    logic          rx_stop;
    logic          fr_valid;
    logic          fr_ready;
    logic [7:0]    fr_data;
    logic [LW-1:0] fr_len;
    logic          mem_re, mem_we, mem_half;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic [15:0]   mem_rdata;
    logic          rx_event;

    int n_chk  = 0;
    int n_fail = 0;
    int wr_cnt = 0;
    int ev_cnt = 0;
    int exp_idx = 0;
    logic [7:0] mem [int unsigned];
    logic [7:0] pay [64];
    logic [7:0] snap [RING];

    always #10 clk = ~clk;   // 50 MHz

    rxr_ring_writer dut (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .rx_stop(rx_stop),
        .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_data(fr_data), .fr_len(fr_len),
        .mem_re(mem_re), .mem_we(mem_we), .mem_half(mem_half), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rx_event(rx_event)
    );

    function automatic logic [7:0] rdb(input int unsigned a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    // Memory model with one-cycle read latency, plus write and event monitors.
    always @(posedge clk) begin
        if (mem_we) begin
            mem[32'(mem_addr)] = mem_wdata[7:0];
            if (mem_half) mem[32'(mem_addr) + 1] = mem_wdata[15:8];
            wr_cnt = wr_cnt + 1;
        end
        if (mem_re)
            mem_rdata <= mem_half ? {rdb(32'(mem_addr) + 1), rdb(32'(mem_addr))}
                                  : {8'h00, rdb(32'(mem_addr))};
        if (rx_event) ev_cnt = ev_cnt + 1;
    end

    function automatic int unsigned desc(input int i);
        return BASE + i * 8;
    endfunction

    function automatic int unsigned buf_of(input int i);
        return 32'h0001_2000 + i * 256;
    endfunction

    // Reference search: first exact-owned entry within ring size minus one.
    function automatic int find_tgt(input int idx);
        for (int k = 0; k < RING - 1; k++)
            if (snap[(idx + k) % RING] == 8'h80) return (idx + k) % RING;
        return -1;
    endfunction

    task automatic check(input bit ok, input string rq, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, expv);
        end
    endtask

    task automatic setup_ring(input logic [7:0] f [RING]);
        for (int i = 0; i < RING; i++) begin
            mem[desc(i)]     = 8'h20 + 8'(i);   // low address, high byte first
            mem[desc(i) + 1] = 8'h00;
            mem[desc(i) + 2] = f[i];
            mem[desc(i) + 3] = 8'h01;
            snap[i]          = f[i];
        end
    endtask

    task automatic run_frame(input int len, input bit stp, input string tag);
        int tgt, w0, e0, i, bad;
        bit rdy;
        tgt = stp ? -1 : find_tgt(exp_idx);
        for (int b = 0; b < len; b++) pay[b] = 8'($urandom);
        w0 = wr_cnt;
        e0 = ev_cnt;
        @(negedge clk);
        rx_stop  = stp;
        fr_valid = 1'b1;
        fr_len   = LW'(len);
        i = 0;
        while (i < len) begin
            fr_data = pay[i];
            rdy = fr_ready;
            @(posedge clk);
            if (rdy) i++;
            @(negedge clk);
        end
        fr_valid = 1'b0;
        rx_stop  = 1'b0;
        repeat (4) @(negedge clk);
        // R5: one event per accepted frame, none for a drop
        check(ev_cnt - e0 == (tgt >= 0 ? 1 : 0), {"R5 event count ", tag}, ev_cnt - e0, tgt >= 0);
        // R7 R8: count + bytes + flag writes, or none at all
        check(wr_cnt - w0 == (tgt >= 0 ? len + 2 : 0), {"R7 write count ", tag},
              wr_cnt - w0, tgt >= 0 ? len + 2 : 0);
        bad = 0;
        for (int k = 0; k < RING; k++)
            if (k != tgt && rdb(desc(k) + 2) != snap[k]) bad++;
        // R1 R2: untaken descriptors keep their flags
        check(bad == 0, {"R1 R2 other flags ", tag}, bad, 0);
        if (tgt >= 0) begin
            check(rdb(desc(tgt) + 2) == 8'h03, {"R5 returned flag ", tag}, rdb(desc(tgt) + 2), 8'h03);
            check({rdb(desc(tgt) + 6), rdb(desc(tgt) + 7)} == 16'(len + 4), {"R3 count field ", tag},
                  {rdb(desc(tgt) + 6), rdb(desc(tgt) + 7)}, len + 4);
            bad = 0;
            for (int b = 0; b < len; b++) if (rdb(buf_of(tgt) + b) != pay[b]) bad++;
            check(bad == 0, {"R4 buffer bytes ", tag}, bad, 0);
            exp_idx = (exp_idx + 1) % RING;   // R6: one step from saved index
        end
    endtask

    task automatic fill_all(input logic [7:0] v);
        logic [7:0] f [RING];
        for (int i = 0; i < RING; i++) f[i] = v;
        setup_ring(f);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] f [RING];
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; ring_base = AW'(BASE); rx_stop = 1'b0;
        fr_valid = 1'b0; fr_data = '0; fr_len = '0;
        repeat (3) @(negedge clk);
        // R9: outputs quiet in reset
        check(!fr_ready && !mem_we && !mem_re && !rx_event, "R9 reset outputs",
              {fr_ready, mem_we, mem_re, rx_event}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!fr_ready && !mem_we && !mem_re, "R9 idle after reset", {fr_ready, mem_we, mem_re}, 0);

        // R9 R1: all owned, index 0 taken first
        fill_all(8'h80);
        run_frame(10, 1'b0, "first");

        // R1: 0x81 passed over, 0x80 taken; R6: index then 2, not 3
        for (int i = 0; i < RING; i++) f[i] = 8'h00;
        f[1] = 8'h81; f[2] = 8'h80;
        setup_ring(f);
        run_frame(7, 1'b0, "exact match");
        check(exp_idx == 2, "R6 index model", exp_idx, 2);

        // R6: with all owned, entry 2 is taken next
        fill_all(8'h80);
        run_frame(5, 1'b0, "index step");

        // R2: only the entry before the saved index is owned -> drop
        for (int i = 0; i < RING; i++) f[i] = 8'h00;
        f[(exp_idx + RING - 1) % RING] = 8'h80;
        setup_ring(f);
        run_frame(6, 1'b0, "short lap");

        // R7: stop at frame start drops even with owned entries
        fill_all(8'h80);
        run_frame(9, 1'b1, "stopped");

        // R4: single-byte frame
        fill_all(8'h80);
        run_frame(1, 1'b0, "one byte");

        // Random mix of ownership patterns, lengths and stop
        for (int n = 0; n < 40; n++) begin
            for (int i = 0; i < RING; i++) begin
                case ($urandom % 8)
                    0, 1, 2, 3: f[i] = 8'h80;
                    4:          f[i] = 8'h00;
                    5:          f[i] = 8'h03;
                    default:    f[i] = 8'h80 | (8'h01 << ($urandom % 7));
                endcase
            end
            setup_ring(f);
            run_frame(1 + int'($urandom % 48), ($urandom % 10) == 0, "random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule